// File: doc/BRIEF.md
# UART Interrupt Priority Identification Unit

This block gathers the five interrupt causes of a 16550-style serial port. It keeps a pending state for each one and reports the most urgent enabled cause as a 4-bit identification code. It also drives a single interrupt request line. The register interface feeds it read strobes (line status, modem status, receive buffer, identification register) and a write strobe for the transmit holding register. Each pending state clears according to the rule that belongs to its source. The receive and transmit FIFO fill levels arrive as plain counts. The block derives the receive-data condition from the receive level and a selectable trigger threshold.

Transmit-holding-empty gets special treatment when the transmit FIFO runs dry. If the FIFO held two or more characters at once since the previous empty event, the interrupt is raised at once. If it did not, the interrupt waits one character time without the stop bit, counted in 16x baud ticks. This spares software a flood of empty interrupts while it is still filling the FIFO at start-up.

Top module: `uart_irq_id`

## Requirements
- R1: After reset the identification code is 0001, the request line is low and no source is pending. The reset state counts the transmit FIFO as already empty, so no empty event follows reset.
- R2: The codes are 0110 for line status, 0100 for receive data, 1100 for character time-out, 0010 for transmit empty, 0000 for modem status and 0001 for none. The highest enabled pending source is reported, in this order: line status, then receive data and time-out (receive data first when both are pending), then transmit empty, then modem status.
- R3: A one-cycle line error pulse makes line status pending from the next cycle. A line status read clears it. An error arriving in the same cycle as the read leaves it pending.
- R4: Receive data is pending whenever the receive level is at or above the trigger threshold. Trigger select 0, 1, 2 and 3 gives a threshold of 1, DEPTH/4, DEPTH/2 and DEPTH-2 characters.
- R5: A time-out pulse makes character time-out pending. A receive buffer read clears it, and so does an empty receive FIFO. The clear wins over a pulse in the same cycle.
- R6: A modem line change pulse makes modem status pending. A modem status read clears it.
- R7: Suppose the transmit level is sampled at 2 or more at some time after the last empty event. Then, when the level next reaches 0, transmit empty is pending from the following cycle. Each new empty event resets this record.
- R8: Otherwise, an empty event starts a wait of (6 + word-length select) x OVS baud ticks, with select 0..3 meaning 5..8 data bits. Transmit empty becomes pending on the last tick. If the transmit level leaves 0 during the wait, the wait is abandoned.
- R9: A transmit holding write clears transmit empty, and it wins over a same-cycle set. An identification register read clears transmit empty only while 0010 is the code on the output.
- R10: Enable bit 0 covers receive data and time-out, bit 1 transmit empty, bit 2 line status and bit 3 modem status. A masked source is left out of the code and the request. The request is high exactly when code bit 0 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ier_i | input | 4 | Per-source interrupt enables |
| wlen_i | input | 2 | Word length select, 0..3 for 5..8 data bits |
| rx_trig_i | input | 2 | Receive trigger threshold select |
| rx_level_i | input | LVL_W | Receive FIFO fill count |
| tx_level_i | input | LVL_W | Transmit FIFO fill count |
| baud_tick_i | input | 1 | One pulse per 16x baud period |
| line_err_i | input | 1 | Overrun, parity, framing or break event |
| modem_chg_i | input | 1 | Change on any modem input line |
| rx_tmo_i | input | 1 | Character time-out event |
| lsr_rd_i | input | 1 | Line status register read strobe |
| msr_rd_i | input | 1 | Modem status register read strobe |
| rbr_rd_i | input | 1 | Receive buffer read strobe |
| thr_wr_i | input | 1 | Transmit holding register write strobe |
| iir_rd_i | input | 1 | Identification register read strobe |
| iid_o | output | 4 | Identification code |
| irq_o | output | 1 | Interrupt request |

## Verification
Two events in the same cycle are the main concern. The first is an identification read while a transmit-empty interrupt is pending behind a line status interrupt. The read must not clear the transmit-empty state, because 0010 is not the code on display. The bench raises both sources, strobes the identification read, then clears line status with its own read, and expects 0010 to appear. It also checks that transmit empty stays clear when the transmit level drops to zero in the same cycle as a holding register write, and that a line error arriving together with a status read leaves the error pending.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam logic [3:0] IID_NONE = 4'b0001;
    localparam logic [3:0] IID_RLS  = 4'b0110;
    localparam logic [3:0] IID_RDA  = 4'b0100;
    localparam logic [3:0] IID_CTI  = 4'b1100;
    localparam logic [3:0] IID_THRE = 4'b0010;
    localparam logic [3:0] IID_MS   = 4'b0000;

    // enable bit positions
    localparam int EN_RX   = 0;
    localparam int EN_THRE = 1;
    localparam int EN_RLS  = 2;
    localparam int EN_MS   = 3;

    typedef struct packed {
        logic rls;
        logic rda;
        logic cti;
        logic thre;
        logic ms;
    } irq_vec_t;

endpackage

// File: rtl/uart_rx_trig_cmp.sv
module uart_rx_trig_cmp #(
    parameter int FIFO_DEPTH = 16,
    localparam int LVL_W = $clog2(FIFO_DEPTH + 1)
) (
    input  logic [1:0]       trig_sel_i,
    input  logic [LVL_W-1:0] level_i,
    output logic             above_o
);

    localparam int TRIG_Q1 = (FIFO_DEPTH / 4 > 1) ? FIFO_DEPTH / 4 : 1;
    localparam int TRIG_Q2 = (FIFO_DEPTH / 2 > 1) ? FIFO_DEPTH / 2 : 1;
    localparam int TRIG_Q3 = (FIFO_DEPTH > 3) ? FIFO_DEPTH - 2 : 1;

    logic [LVL_W-1:0] thresh;

    always_comb begin
        case (trig_sel_i)
            2'd0:    thresh = LVL_W'(1);
            2'd1:    thresh = LVL_W'(TRIG_Q1);
            2'd2:    thresh = LVL_W'(TRIG_Q2);
            default: thresh = LVL_W'(TRIG_Q3);
        endcase
        above_o = (level_i >= thresh);
    end

endmodule

// File: rtl/uart_thre_qual.sv
module uart_thre_qual #(
    parameter int FIFO_DEPTH = 16,
    parameter int OVS        = 16,
    localparam int LVL_W = $clog2(FIFO_DEPTH + 1),
    localparam int CNT_W = $clog2(9 * OVS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       wlen_i,
    input  logic [LVL_W-1:0] tx_level_i,
    input  logic             baud_tick_i,
    input  logic             thr_wr_i,
    input  logic             iir_clr_i,
    output logic             pend_o
);

    typedef struct packed {
        logic             empty;
        logic             multi;
        logic             waiting;
        logic             pend;
        logic [CNT_W-1:0] cnt;
    } thre_st_t;

    thre_st_t st_q, st_d;
    logic     empty_now;
    logic     empty_rise;
    logic [CNT_W-1:0] delay;

    always_comb begin
        empty_now  = (tx_level_i == '0);
        empty_rise = empty_now && !st_q.empty;
        delay      = CNT_W'(OVS * (int'(wlen_i) + 6));

        st_d       = st_q;
        st_d.empty = empty_now;

        if (tx_level_i >= LVL_W'(2)) begin
            st_d.multi = 1'b1;
        end
        if (!empty_now) begin
            st_d.waiting = 1'b0;
        end

        if (empty_rise) begin
            st_d.multi = 1'b0;
            if (st_q.multi) begin
                st_d.pend = 1'b1;
            end else begin
                st_d.waiting = 1'b1;
                st_d.cnt     = delay;
            end
        end else if (st_q.waiting && empty_now && baud_tick_i) begin
            if (st_q.cnt <= CNT_W'(1)) begin
                st_d.waiting = 1'b0;
                st_d.pend    = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - CNT_W'(1);
            end
        end

        if (thr_wr_i || iir_clr_i) begin
            st_d.pend    = 1'b0;
            st_d.waiting = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{empty: 1'b1, multi: 1'b0, waiting: 1'b0, pend: 1'b0, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o = st_q.pend;

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
    import uart_irq_pkg::*;
(
    input  irq_vec_t   pend_i,
    input  logic [3:0] ier_i,
    output logic [3:0] iid_o,
    output logic       irq_o
);

    irq_vec_t act;

    always_comb begin
        act.rls  = pend_i.rls  & ier_i[EN_RLS];
        act.rda  = pend_i.rda  & ier_i[EN_RX];
        act.cti  = pend_i.cti  & ier_i[EN_RX];
        act.thre = pend_i.thre & ier_i[EN_THRE];
        act.ms   = pend_i.ms   & ier_i[EN_MS];

        if (act.rls)       iid_o = IID_RLS;
        else if (act.rda)  iid_o = IID_RDA;
        else if (act.cti)  iid_o = IID_CTI;
        else if (act.thre) iid_o = IID_THRE;
        else if (act.ms)   iid_o = IID_MS;
        else               iid_o = IID_NONE;

        irq_o = |act;
    end

endmodule

// File: rtl/uart_irq_id.sv
module uart_irq_id
    import uart_irq_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int OVS        = 16,
    localparam int LVL_W = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       ier_i,
    input  logic [1:0]       wlen_i,
    input  logic [1:0]       rx_trig_i,
    input  logic [LVL_W-1:0] rx_level_i,
    input  logic [LVL_W-1:0] tx_level_i,
    input  logic             baud_tick_i,
    input  logic             line_err_i,
    input  logic             modem_chg_i,
    input  logic             rx_tmo_i,
    input  logic             lsr_rd_i,
    input  logic             msr_rd_i,
    input  logic             rbr_rd_i,
    input  logic             thr_wr_i,
    input  logic             iir_rd_i,
    output logic [3:0]       iid_o,
    output logic             irq_o
);

    typedef struct packed {
        logic rls;
        logic ms;
        logic cti;
    } src_st_t;

    src_st_t  src_q, src_d;
    logic     rda_cond;
    logic     thre_pend;
    logic     iir_thre_clr;
    irq_vec_t pend;

    uart_rx_trig_cmp #(
        .FIFO_DEPTH (FIFO_DEPTH)
    ) u_trig (
        .trig_sel_i (rx_trig_i),
        .level_i    (rx_level_i),
        .above_o    (rda_cond)
    );

    assign iir_thre_clr = iir_rd_i && (iid_o == IID_THRE);

    uart_thre_qual #(
        .FIFO_DEPTH (FIFO_DEPTH),
        .OVS        (OVS)
    ) u_thre (
        .clk         (clk),
        .rst_n       (rst_n),
        .wlen_i      (wlen_i),
        .tx_level_i  (tx_level_i),
        .baud_tick_i (baud_tick_i),
        .thr_wr_i    (thr_wr_i),
        .iir_clr_i   (iir_thre_clr),
        .pend_o      (thre_pend)
    );

    always_comb begin
        src_d     = src_q;
        src_d.rls = line_err_i  | (src_q.rls & ~lsr_rd_i);
        src_d.ms  = modem_chg_i | (src_q.ms  & ~msr_rd_i);
        src_d.cti = (rx_tmo_i | src_q.cti) & ~rbr_rd_i & (rx_level_i != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q <= '0;
        end else begin
            src_q <= src_d;
        end
    end

    always_comb begin
        pend.rls  = src_q.rls;
        pend.rda  = rda_cond;
        pend.cti  = src_q.cti;
        pend.thre = thre_pend;
        pend.ms   = src_q.ms;
    end

    uart_irq_prio u_prio (
        .pend_i (pend),
        .ier_i  (ier_i),
        .iid_o  (iid_o),
        .irq_o  (irq_o)
    );

endmodule

// File: rtl/uart_irq_id_chk.sv
module uart_irq_id_chk
    import uart_irq_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] ier_i,
    input logic       line_err_i,
    input logic       modem_chg_i,
    input logic       msr_rd_i,
    input logic       rbr_rd_i,
    input logic       thr_wr_i,
    input logic [3:0] iid_o,
    input logic       irq_o
);

    // R3
    rls_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_err_i && ier_i[EN_RLS]) |=> (iid_o == IID_RLS));

    // R9
    thre_wr_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        thr_wr_i |=> (iid_o != IID_THRE));

    // R6
    ms_rd_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msr_rd_i && !modem_chg_i) |=> (iid_o != IID_MS));

    // R5
    cti_rd_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rbr_rd_i |=> (iid_o != IID_CTI));

    // R10
    irq_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == !iid_o[0]);

    // R2
    iid_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iid_o == IID_NONE) || (iid_o == IID_RLS) || (iid_o == IID_RDA) ||
        (iid_o == IID_CTI) || (iid_o == IID_THRE) || (iid_o == IID_MS));

endmodule

bind uart_irq_id uart_irq_id_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ier_i       (ier_i),
    .line_err_i  (line_err_i),
    .modem_chg_i (modem_chg_i),
    .msr_rd_i    (msr_rd_i),
    .rbr_rd_i    (rbr_rd_i),
    .thr_wr_i    (thr_wr_i),
    .iid_o       (iid_o),
    .irq_o       (irq_o)
);

// File: tb/uart_irq_id_tb.sv
module uart_irq_id_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 16;
    localparam int OVS   = 16;
    localparam int LW    = $clog2(DEPTH + 1);

    // {line_err, modem_chg, rx_tmo, trig[1:0], rx_level[4:0], ier[3:0], exp_iid[3:0], exp_irq}
    localparam int NV = 14;
    localparam logic [18:0] VEC [NV] = '{
        {3'b000, 2'd2, 5'd0,  4'hF, 4'b0001, 1'b0},
        {3'b100, 2'd2, 5'd0,  4'hF, 4'b0110, 1'b1},
        {3'b000, 2'd2, 5'd8,  4'hF, 4'b0100, 1'b1},
        {3'b001, 2'd2, 5'd3,  4'hF, 4'b1100, 1'b1},
        {3'b010, 2'd2, 5'd0,  4'hF, 4'b0000, 1'b1},
        {3'b110, 2'd2, 5'd8,  4'hF, 4'b0110, 1'b1},
        {3'b001, 2'd2, 5'd9,  4'hF, 4'b0100, 1'b1},
        {3'b011, 2'd2, 5'd2,  4'hF, 4'b1100, 1'b1},
        {3'b110, 2'd2, 5'd0,  4'hB, 4'b0000, 1'b1},
        {3'b111, 2'd2, 5'd4,  4'h0, 4'b0001, 1'b0},
        {3'b000, 2'd2, 5'd7,  4'hF, 4'b0001, 1'b0},
        {3'b000, 2'd3, 5'd14, 4'hF, 4'b0100, 1'b1},
        {3'b000, 2'd3, 5'd13, 4'hF, 4'b0001, 1'b0},
        {3'b000, 2'd0, 5'd1,  4'hF, 4'b0100, 1'b1}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [3:0]    ier = 4'h0;
    logic [1:0]    wlen = 2'd0;
    logic [1:0]    trig = 2'd0;
    logic [LW-1:0] rx_lvl = '0;
    logic [LW-1:0] tx_lvl = '0;
    logic          tick = 1'b0;
    logic          lerr = 1'b0, mchg = 1'b0, tmo = 1'b0;
    logic          lsr_rd = 1'b0, msr_rd = 1'b0, rbr_rd = 1'b0, thr_wr = 1'b0, iir_rd = 1'b0;
    logic [3:0]    iid;
    logic          irq;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    uart_irq_id #(.FIFO_DEPTH(DEPTH), .OVS(OVS)) u_dut (
        .clk (clk), .rst_n (rst_n), .ier_i (ier), .wlen_i (wlen),
        .rx_trig_i (trig), .rx_level_i (rx_lvl), .tx_level_i (tx_lvl),
        .baud_tick_i (tick), .line_err_i (lerr), .modem_chg_i (mchg),
        .rx_tmo_i (tmo), .lsr_rd_i (lsr_rd), .msr_rd_i (msr_rd),
        .rbr_rd_i (rbr_rd), .thr_wr_i (thr_wr), .iir_rd_i (iir_rd),
        .iid_o (iid), .irq_o (irq)
    );

    task automatic check(input string req, input logic [3:0] exp_iid, input logic exp_irq);
        n_chk++;
        if (iid !== exp_iid || irq !== exp_irq) begin
            n_err++;
            $display("FAIL %s: iid=%b irq=%b expected iid=%b irq=%b", req, iid, irq, exp_iid, exp_irq);
        end
    endtask

    // one clock: strobes set at a falling edge are removed at the next one
    task automatic cyc();
        @(negedge clk);
        lerr = 0; mchg = 0; tmo = 0; tick = 0;
        lsr_rd = 0; msr_rd = 0; rbr_rd = 0; thr_wr = 0; iir_rd = 0;
    endtask

    task automatic clear_all();
        lsr_rd = 1; msr_rd = 1; rbr_rd = 1; rx_lvl = '0;
        cyc();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset", 4'b0001, 1'b0);
        rst_n = 1'b1;
        cyc();
        check("R1 after reset", 4'b0001, 1'b0);

        // table walk: R2 R3 R4 R5 R6 R10
        for (int i = 0; i < NV; i++) begin
            clear_all();
            trig = VEC[i][15:14]; rx_lvl = VEC[i][13:9]; ier = VEC[i][8:5];
            lerr = VEC[i][18]; mchg = VEC[i][17]; tmo = VEC[i][16];
            cyc();
            check($sformatf("R2/R4/R10 vector %0d", i), VEC[i][4:1], VEC[i][0]);
        end

        // R3: read clears; error with read keeps pending
        clear_all(); ier = 4'hF;
        lerr = 1; cyc();
        lsr_rd = 1; cyc();
        check("R3 lsr read clears", 4'b0001, 1'b0);
        lerr = 1; cyc();
        lerr = 1; lsr_rd = 1; cyc();
        check("R3 error with read", 4'b0110, 1'b1);
        lsr_rd = 1; cyc();

        // R5: clear by read, by empty FIFO, read wins over pulse
        rx_lvl = 5'd2; trig = 2'd2; tmo = 1; cyc();
        check("R5 timeout set", 4'b1100, 1'b1);
        rbr_rd = 1; cyc();
        check("R5 read clears", 4'b0001, 1'b0);
        tmo = 1; cyc();
        rx_lvl = '0; cyc();
        check("R5 empty FIFO clears", 4'b0001, 1'b0);
        rx_lvl = 5'd1; tmo = 1; rbr_rd = 1; cyc();
        check("R5 read wins", 4'b0001, 1'b0);
        rx_lvl = '0;

        // R6
        mchg = 1; cyc();
        check("R6 set", 4'b0000, 1'b1);
        msr_rd = 1; cyc();
        check("R6 read clears", 4'b0001, 1'b0);

        // R7 immediate after FIFO held two
        ier = 4'h2;
        tx_lvl = 5'd2; cyc();
        tx_lvl = 5'd1; cyc();
        tx_lvl = 5'd0; cyc();
        check("R7 immediate", 4'b0010, 1'b1);
        // R9 iir read while reported clears, no re-raise
        iir_rd = 1; cyc();
        check("R9 iir read clears", 4'b0001, 1'b0);
        repeat (5) cyc();
        check("R9 stays clear", 4'b0001, 1'b0);

        // R8 delayed, multi record reset by last event (wlen 0: 96 ticks)
        thr_wr = 1; tx_lvl = 5'd1; cyc();
        tx_lvl = 5'd0; cyc();
        check("R7 record reset, not immediate", 4'b0001, 1'b0);
        for (int k = 0; k < 6 * OVS - 1; k++) begin tick = 1; cyc(); end
        check("R8 before last tick", 4'b0001, 1'b0);
        tick = 1; cyc();
        check("R8 after last tick", 4'b0010, 1'b1);

        // R9 write clears
        thr_wr = 1; tx_lvl = 5'd1; cyc();
        check("R9 write clears", 4'b0001, 1'b0);

        // R8 wlen 3: 144 ticks
        wlen = 2'd3;
        tx_lvl = 5'd0; cyc();
        for (int k = 0; k < 9 * OVS - 1; k++) begin tick = 1; cyc(); end
        check("R8 wlen3 before", 4'b0001, 1'b0);
        tick = 1; cyc();
        check("R8 wlen3 after", 4'b0010, 1'b1);

        // R8 abort on refill
        thr_wr = 1; tx_lvl = 5'd1; cyc();
        tx_lvl = 5'd0; cyc();
        for (int k = 0; k < 10; k++) begin tick = 1; cyc(); end
        tx_lvl = 5'd1; cyc();
        for (int k = 0; k < 9 * OVS + 4; k++) begin tick = 1; cyc(); end
        check("R8 abort on refill", 4'b0001, 1'b0);

        // R9 write wins over same-cycle immediate set
        tx_lvl = 5'd2; cyc();
        tx_lvl = 5'd0; thr_wr = 1; cyc();
        check("R9 write wins", 4'b0001, 1'b0);
        tx_lvl = 5'd1; cyc();

        // R9 iir read while line status shown leaves THRE pending
        ier = 4'hF;
        tx_lvl = 5'd2; cyc();
        tx_lvl = 5'd0; lerr = 1; cyc();
        check("R2 line status over THRE", 4'b0110, 1'b1);
        iir_rd = 1; cyc();
        lsr_rd = 1; cyc();
        check("R9 iir read under other code", 4'b0010, 1'b1);
        ier = 4'hD; cyc();
        check("R10 THRE masked", 4'b0001, 1'b0);

        finish_run();
    end

endmodule